// File: doc/BRIEF.md
# Descriptor-Driven Scatter-Gather DMA Engine

This block moves the data of one disk command between a local sector buffer and system memory. The disk protocol side supplies three things with a one-cycle start pulse: the address of a descriptor table, the transfer direction and the total byte count of the command. The engine then runs on its own. It reads 8-byte descriptors from memory. Each descriptor names one memory region. The engine moves that region in bursts that never cross a page boundary, and it steps through the table until it reaches the descriptor marked as the last.

The memory side is a request port. A request is one cycle wide and carries an address, a byte length and a direction. Data then moves in 16-bit beats, paced by the memory side. When the memory port reports busy, the engine does not queue the request. It waits a fixed back-off and tries again. The buffer side is a simple word-addressed port whose word address starts at zero and climbs through the whole command. When the table ends, the engine compares the bytes it moved with the command byte count. It then emits either a completion pulse or an error pulse, and it keeps separate traffic statistics for each direction.

Top module: `sg_dma_engine`

## Requirements
- R1: After reset the engine is idle: `active`, `mem_req`, `done` and `err` are low, and all six statistics outputs are zero.
- R2: `start` is accepted only while the engine is idle and `dev_ready` is high; otherwise it has no effect. When it is accepted, the first descriptor request appears in the cycle right after the start cycle. That request is a read of 8 bytes, and its address is `start_base` with bits 1:0 forced to zero.
- R3: A descriptor is four 16-bit beats read in this order: region address bits 15:0, region address bits 31:16, byte count, flags. In the byte count, bit 0 is ignored. Bit 15 of the flags beat marks the last descriptor. Each following descriptor is fetched 8 bytes above the previous one.
- R4: Each region is moved in bursts. The length of each burst is the smaller of the bytes still left in the region and the bytes up to the next `PAGE_BYTES` boundary, so no burst crosses a page.
- R5: With `start_to_mem` = 0, memory is read and the buffer is written. With `start_to_mem` = 1, the buffer is read and memory is written (`mem_we` = 1). The buffer word address starts at 0 and rises by one for each beat, across bursts and across descriptors.
- R6: If `mem_busy` is high in a cycle where the engine would issue a request, no request is made. The engine waits `BACKOFF` cycles and then tries again.
- R7: When the last region finishes, the engine pulses `done` for one cycle if the bytes moved equal `cmd_bytes`, or pulses `err` otherwise (whether it moved too many bytes or too few). In both cases it returns to idle.
- R8: Each data burst adds one to the transaction count of its direction and adds its length to the byte count of that direction. It also adds one to the full-page count of that direction when its length equals `PAGE_BYTES`. The statistics of the other direction stay unchanged.
- R9: A byte-count field whose bits 15:1 are all zero stands for a 65536-byte region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse from the protocol engine |
| start_base | input | AW | Descriptor table address (bits 1:0 ignored) |
| start_to_mem | input | 1 | 1: buffer to memory, 0: memory to buffer |
| cmd_bytes | input | CMD_W | Total byte count of the command |
| dev_ready | input | 1 | Device is prepared for a DMA transfer |
| mem_req | output | 1 | One-cycle request on the memory port |
| mem_we | output | 1 | Request is a memory write |
| mem_addr | output | AW | Byte address of the request |
| mem_len | output | LEN_W | Byte length of the request |
| mem_busy | input | 1 | Memory port busy or has a request pending |
| mem_rvalid | input | 1 | Read beat present on `mem_rdata` |
| mem_rdata | input | 16 | Read beat data |
| mem_wready | input | 1 | Memory accepts `mem_wdata` this cycle |
| mem_wdata | output | 16 | Write beat data |
| buf_addr | output | BUF_AW | Buffer word address |
| buf_we | output | 1 | Buffer write strobe |
| buf_wdata | output | 16 | Buffer write data |
| buf_rdata | input | 16 | Buffer read data (combinational from `buf_addr`) |
| done | output | 1 | Successful completion pulse |
| err | output | 1 | Byte-count mismatch pulse |
| active | output | 1 | Engine is running |
| rd_txs | output | STAT_W | Memory-read burst count |
| rd_bytes | output | STAT_W | Memory-read byte count |
| rd_pages | output | STAT_W | Memory-read full-page bursts |
| wr_txs | output | STAT_W | Memory-write burst count |
| wr_bytes | output | STAT_W | Memory-write byte count |
| wr_pages | output | STAT_W | Memory-write full-page bursts |

## Verification
The assertions rely on the memory side following a few rules. It sends exactly `mem_len`/2 beats after each request. It raises no beat before the request has been accepted. It gives descriptor and region addresses that are even. The bench's memory responder follows these rules by design. It loads the beat count at the request edge and then counts down. Its descriptors always carry even region addresses. Its stalls and its busy windows only delay beats or requests and never add any.

// File: rtl/sg_dma_engine.sv
module sg_dma_engine #(
  parameter int AW         = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int BACKOFF    = 16,
  parameter int BUF_AW     = 16,
  parameter int CMD_W      = 18,
  parameter int STAT_W     = 32,
  parameter int LEN_W      = $clog2(PAGE_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     start_base,
  input  logic              start_to_mem,
  input  logic [CMD_W-1:0]  cmd_bytes,
  input  logic              dev_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [LEN_W-1:0]  mem_len,
  input  logic              mem_busy,
  input  logic              mem_rvalid,
  input  logic [15:0]       mem_rdata,
  input  logic              mem_wready,
  output logic [15:0]       mem_wdata,
  output logic [BUF_AW-1:0] buf_addr,
  output logic              buf_we,
  output logic [15:0]       buf_wdata,
  input  logic [15:0]       buf_rdata,
  output logic              done,
  output logic              err,
  output logic              active,
  output logic [STAT_W-1:0] rd_txs,
  output logic [STAT_W-1:0] rd_bytes,
  output logic [STAT_W-1:0] rd_pages,
  output logic [STAT_W-1:0] wr_txs,
  output logic [STAT_W-1:0] wr_bytes,
  output logic [STAT_W-1:0] wr_pages
);
  localparam int PG_W = $clog2(PAGE_BYTES);
  localparam int BO_W = $clog2(BACKOFF + 1);

  typedef enum logic [2:0] {S_IDLE, S_DISS, S_DDAT, S_CISS, S_CDAT, S_BACK} st_t;

  st_t               st;
  logic              to_mem, eot, ret_chunk;
  logic [AW-1:0]     tbl_ptr, reg_addr;
  logic [16:0]       reg_left, new_len;
  logic [CMD_W-1:0]  cmd_left;
  logic [BUF_AW-1:0] bptr;
  logic [1:0]        dbeat;
  logic [15:0]       d0, d1, d2;
  logic [LEN_W-2:0]  beats_left;
  logic [BO_W-1:0]   bo_cnt;
  logic [LEN_W-1:0]  to_page, chunk;
  logic              issuing, beat, full_page;
  logic              unused_bits;

  assign to_page   = LEN_W'(PAGE_BYTES) - LEN_W'(reg_addr[PG_W-1:0]);
  assign chunk     = (reg_left < 17'(to_page)) ? reg_left[LEN_W-1:0] : to_page;
  assign full_page = (chunk == LEN_W'(PAGE_BYTES));
  assign new_len   = (d2[15:1] == '0) ? 17'h10000 : {1'b0, d2[15:1], 1'b0};
  assign unused_bits = d2[0] ^ d0[0];

  assign issuing   = (st == S_DISS || st == S_CISS) && !mem_busy;
  assign mem_req   = issuing;
  assign mem_we    = (st == S_CISS) && to_mem;
  assign mem_addr  = (st == S_DISS) ? tbl_ptr : reg_addr;
  assign mem_len   = (st == S_DISS) ? LEN_W'(8) : chunk;
  assign beat      = (st == S_CDAT) && (to_mem ? mem_wready : mem_rvalid);
  assign buf_addr  = bptr;
  assign buf_we    = (st == S_CDAT) && !to_mem && mem_rvalid;
  assign buf_wdata = mem_rdata;
  assign mem_wdata = buf_rdata;
  assign active    = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; to_mem <= 1'b0; eot <= 1'b0; ret_chunk <= 1'b0;
      tbl_ptr <= '0; reg_addr <= '0; reg_left <= '0; cmd_left <= '0;
      bptr <= '0; dbeat <= '0; d0 <= '0; d1 <= '0; d2 <= '0;
      beats_left <= '0; bo_cnt <= '0; done <= 1'b0; err <= 1'b0;
      rd_txs <= '0; rd_bytes <= '0; rd_pages <= '0;
      wr_txs <= '0; wr_bytes <= '0; wr_pages <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE: if (start && dev_ready) begin
          tbl_ptr  <= start_base & ~AW'(3);
          to_mem   <= start_to_mem;
          cmd_left <= cmd_bytes;
          bptr     <= '0;
          st       <= S_DISS;
        end
        S_DISS: if (mem_busy) begin
          ret_chunk <= 1'b0; bo_cnt <= BO_W'(BACKOFF - 1); st <= S_BACK;
        end else begin
          dbeat <= '0; st <= S_DDAT;
        end
        S_DDAT: if (mem_rvalid) begin
          dbeat <= dbeat + 2'd1;
          case (dbeat)
            2'd0: d0 <= mem_rdata;
            2'd1: d1 <= mem_rdata;
            2'd2: d2 <= mem_rdata;
            default: begin
              reg_addr <= AW'({d1, d0[15:1], 1'b0});
              reg_left <= new_len;
              eot      <= mem_rdata[15];
              tbl_ptr  <= tbl_ptr + AW'(8);
              st       <= S_CISS;
            end
          endcase
        end
        S_CISS: if (mem_busy) begin
          ret_chunk <= 1'b1; bo_cnt <= BO_W'(BACKOFF - 1); st <= S_BACK;
        end else begin
          beats_left <= chunk[LEN_W-1:1];
          st <= S_CDAT;
          if (to_mem) begin
            wr_txs   <= wr_txs + 1'b1;
            wr_bytes <= wr_bytes + STAT_W'(chunk);
            if (full_page) wr_pages <= wr_pages + 1'b1;
          end else begin
            rd_txs   <= rd_txs + 1'b1;
            rd_bytes <= rd_bytes + STAT_W'(chunk);
            if (full_page) rd_pages <= rd_pages + 1'b1;
          end
        end
        S_CDAT: if (beat) begin
          bptr       <= bptr + 1'b1;
          beats_left <= beats_left - 1'b1;
          if (beats_left == 1) begin
            reg_addr <= reg_addr + AW'(chunk);
            reg_left <= reg_left - 17'(chunk);
            cmd_left <= cmd_left - CMD_W'(chunk);
            if (reg_left == 17'(chunk)) begin
              if (eot) begin
                st <= S_IDLE;
                if (cmd_left == CMD_W'(chunk)) done <= 1'b1;
                else err <= 1'b1;
              end else st <= S_DISS;
            end else st <= S_CISS;
          end
        end
        S_BACK: if (bo_cnt == '0) st <= ret_chunk ? S_CISS : S_DISS;
                else bo_cnt <= bo_cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r6_no_req_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_busy);
  a_r4_page_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && st == S_CISS) |->
      (17'(mem_addr[PG_W-1:0]) + 17'(mem_len) <= 17'(PAGE_BYTES)));
  a_r4_even_burst: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (!mem_len[0] && !mem_addr[0] && mem_len != '0));
  a_r2_desc_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && st == S_DISS) |-> (!mem_we && mem_addr[1:0] == 2'b00 && mem_len == LEN_W'(8)));
  a_r2_first_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !$past(active)) |-> (mem_req != mem_busy));
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  a_r7_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !active);
  a_r5_buf_dir: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> !mem_req);
endmodule

// File: tb/sg_dma_engine_tb.sv
module sg_dma_engine_tb;
  localparam int PG = 64;
  localparam int BO = 4;
  localparam int LW = $clog2(PG) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic start = 1'b0, start_to_mem = 1'b0, dev_ready = 1'b1;
  logic [31:0] start_base = '0;
  logic [17:0] cmd_bytes = '0;
  logic mem_req, mem_we, mem_rvalid, mem_wready, mem_busy;
  logic [31:0] mem_addr;
  logic [LW-1:0] mem_len;
  logic [15:0] mem_rdata, mem_wdata, buf_wdata, buf_rdata;
  logic [11:0] buf_addr;
  logic buf_we, done, err, active;
  logic [31:0] rd_txs, rd_bytes, rd_pages, wr_txs, wr_bytes, wr_pages;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic busy_force = 1'b0, busy_rand = 1'b0, stall_en = 1'b0, stall_t = 1'b0;
  always @(posedge clk) stall_t <= ~stall_t;
  assign mem_busy = busy_force | (busy_rand && (cyc % 7 == 3));

  logic [15:0] mem_m [0:4095];
  logic [15:0] bufm  [0:4095];
  int rsp_left = 0;
  logic [31:0] rsp_addr = '0;
  logic rsp_we = 1'b0;
  wire gate = !stall_en || stall_t;
  assign mem_rvalid = (rsp_left != 0) && !rsp_we && gate;
  assign mem_wready = (rsp_left != 0) && rsp_we && gate;
  assign mem_rdata  = mem_m[rsp_addr[12:1]];
  assign buf_rdata  = bufm[buf_addr];

  always @(posedge clk) begin
    if (mem_req) begin
      rsp_left <= int'(mem_len) / 2; rsp_addr <= mem_addr; rsp_we <= mem_we;
    end else if (mem_rvalid || mem_wready) begin
      if (rsp_we) mem_m[rsp_addr[12:1]] <= mem_wdata;
      rsp_addr <= rsp_addr + 2;
      rsp_left <= rsp_left - 1;
    end
    if (buf_we) bufm[buf_addr] <= buf_wdata;
  end

  sg_dma_engine #(.PAGE_BYTES(PG), .BACKOFF(BO), .BUF_AW(12), .CMD_W(18)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_base(start_base),
    .start_to_mem(start_to_mem), .cmd_bytes(cmd_bytes), .dev_ready(dev_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_len(mem_len),
    .mem_busy(mem_busy), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .mem_wready(mem_wready), .mem_wdata(mem_wdata), .buf_addr(buf_addr),
    .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .done(done), .err(err), .active(active),
    .rd_txs(rd_txs), .rd_bytes(rd_bytes), .rd_pages(rd_pages),
    .wr_txs(wr_txs), .wr_bytes(wr_bytes), .wr_pages(wr_pages));

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int i);
    return 16'(i * 37 + 11) ^ 16'hA5C3;
  endfunction
  function automatic logic [15:0] bpat(input int i);
    return 16'(i * 16'h0101) ^ 16'h3C96;
  endfunction

  task automatic burst_model(input int addr, input int len, output int n, output int pg);
    n = 0; pg = 0;
    while (len > 0) begin
      int c = PG - (addr % PG);
      if (len < c) c = len;
      n++; if (c == PG) pg++;
      addr += c; len -= c;
    end
  endtask

  task automatic put_desc(input int slot, input int base, input int cnt, input bit last);
    mem_m[2048 + slot*4 + 0] = 16'(base);
    mem_m[2048 + slot*4 + 1] = 16'(base >> 16);
    mem_m[2048 + slot*4 + 2] = 16'(cnt);
    mem_m[2048 + slot*4 + 3] = last ? 16'h8000 : 16'h0000;
  endtask

  task automatic launch(input logic [31:0] base, input bit tm, input int cmd, output int ok);
    @(negedge clk);
    start = 1'b1; start_base = base; start_to_mem = tm; cmd_bytes = 18'(cmd);
    @(negedge clk);
    start = 1'b0;
    ok = 0;
    for (int w = 0; w < 80000; w++) begin
      if (done || err) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic run_case(input int off, input int len1, input bit tm, input int cdelta);
    int ok, na, pa, nb, pb, bad;
    logic [31:0] t0, b0, p0, ot0;
    bit want_err;
    for (int i = 0; i < 2048; i++) mem_m[i] = pat(i);
    for (int i = 0; i < 4096; i++) bufm[i] = bpat(i);
    put_desc(0, 'h100 + off, len1, 1'b0);
    put_desc(1, 'h600, 65, 1'b1);
    t0 = tm ? wr_txs : rd_txs; b0 = tm ? wr_bytes : rd_bytes; p0 = tm ? wr_pages : rd_pages;
    ot0 = tm ? rd_txs : wr_txs;
    want_err = (cdelta != 0);
    launch(32'h1000 | 32'(off % 4), tm, len1 + 64 + cdelta, ok);
    chk(ok == 1, "R7 completion seen", ok, 1);
    chk(err == want_err && done == !want_err, "R7 done/err outcome", {done, err}, {!want_err, want_err});
    burst_model('h100 + off, len1, na, pa);
    burst_model('h600, 64, nb, pb);
    chk((tm ? wr_txs : rd_txs) - t0 == na + nb, "R4 burst count", (tm ? wr_txs : rd_txs) - t0, na + nb);
    chk((tm ? wr_bytes : rd_bytes) - b0 == len1 + 64, "R8 byte stat", (tm ? wr_bytes : rd_bytes) - b0, len1 + 64);
    chk((tm ? wr_pages : rd_pages) - p0 == pa + pb, "R8 page stat", (tm ? wr_pages : rd_pages) - p0, pa + pb);
    chk((tm ? rd_txs : wr_txs) == ot0, "R8 other direction unchanged", tm ? rd_txs : wr_txs, ot0);
    bad = 0;
    for (int j = 0; j < len1/2 + 32; j++) begin
      int ma = (j < len1/2) ? ('h100 + off)/2 + j : 'h300 + (j - len1/2);
      if (tm) begin if (mem_m[ma] !== bpat(j)) bad++; end
      else    begin if (bufm[j] !== pat(ma)) bad++; end
    end
    chk(bad == 0, tm ? "R5 buffer-to-memory data (R3 addr/count)" : "R5 memory-to-buffer data (R3 addr/count)", bad, 0);
  endtask

  initial begin
    int cs, first, ok, t0, saw;
    repeat (3) @(negedge clk);
    chk(!active && !mem_req && !done && !err, "R1 idle after reset", {active, mem_req, done, err}, 0);
    chk(rd_txs == 0 && rd_bytes == 0 && rd_pages == 0, "R1 read stats zero", rd_txs + rd_bytes + rd_pages, 0);
    chk(wr_txs == 0 && wr_bytes == 0 && wr_pages == 0, "R1 write stats zero", wr_txs + wr_bytes + wr_pages, 0);
    rst_n = 1'b1;
    @(negedge clk);

    dev_ready = 1'b0; saw = 0;
    start = 1'b1; start_base = 32'h1000;
    @(negedge clk); start = 1'b0;
    for (int w = 0; w < 20; w++) begin
      if (mem_req || active) saw++;
      @(negedge clk);
    end
    chk(saw == 0, "R2 start ignored without dev_ready", saw, 0);
    dev_ready = 1'b1;

    put_desc(0, 'h040, 64, 1'b1);
    busy_force = 1'b1;
    start = 1'b1; start_base = 32'h1003; start_to_mem = 1'b0; cmd_bytes = 18'd64;
    cs = cyc; first = -1;
    @(negedge clk); start = 1'b0;
    for (int w = 0; w < 200 && first < 0; w++) begin
      if (cyc >= cs + 8) busy_force = 1'b0;
      if (mem_req) begin
        first = cyc - cs;
        chk(mem_addr == 32'h1000 && mem_len == 8 && !mem_we, "R2 descriptor request shape", mem_addr, 32'h1000);
      end else @(negedge clk);
    end
    chk(first == 1 + 2*(BO + 1), "R6 back-off retry cycle", first, 1 + 2*(BO + 1));
    for (int w = 0; w < 500 && !done; w++) @(negedge clk);
    chk(done == 1, "R7 done after busy start", done, 1);
    @(negedge clk);

    cs = cyc; first = -1;
    start = 1'b1; start_base = 32'h1000; start_to_mem = 1'b0; cmd_bytes = 18'd64;
    @(negedge clk); start = 1'b0;
    if (mem_req) first = cyc - cs;
    chk(first == 1, "R2 request one cycle after start", first, 1);
    for (int w = 0; w < 500 && !done; w++) @(negedge clk);
    @(negedge clk);

    for (int li = 0; li < 4; li++) begin
      for (int off = 0; off < PG; off += 2) begin
        int lens [4] = '{2, 64, 100, 126};
        busy_rand = (off % 6 == 0);
        stall_en  = (off % 4 == 2);
        run_case(off, lens[li], (off/2 + li) % 2 == 1, 0);
      end
    end
    busy_rand = 1'b0; stall_en = 1'b0;

    run_case(10, 100, 1'b0, 2);
    run_case(12, 100, 1'b1, -2);
    run_case(0, 64, 1'b0, 64);

    put_desc(0, 'h000, 0, 1'b1);
    t0 = rd_txs;
    saw = rd_pages;
    cs = rd_bytes;
    launch(32'h1002, 1'b0, 65536, ok);
    chk(ok == 1 && done == 1, "R9 zero count completes as 64 KB", done, 1);
    chk(rd_bytes - cs == 65536, "R9 zero count byte total", rd_bytes - cs, 65536);
    chk(rd_txs - t0 == 65536/PG && rd_pages - saw == 65536/PG, "R9 zero count full pages", rd_txs - t0, 65536/PG);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule